// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block turns the opcode and function fields of a fetched 32-bit instruction into the control bundle of a single-cycle processor core. It drives the write-back register select, the second ALU operand select, the load result select, the register and memory write enables, the branch and jump selects, the immediate extension mode and a 2-bit ALU operation code. It holds no state and has no clock. Every output settles from the instruction bits alone, within the cycle in which they are presented.

Seven instructions are recognised: register add, register subtract, OR with immediate, load word, store word, branch-if-equal and jump. The decoder first matches each instruction against its code, which gives a one-hot match vector. It then forms every control line as the OR of the matched instructions. The function field matters only when the opcode is the register-format opcode 000000. Any code that matches nothing yields an all-zero bundle, so no state is written and the program counter takes the sequential path.

Top module: `sc_ctrl_decode`

## Requirements
- R1: Instructions are matched on opcode `opcode_i` alone, except the register format (opcode 000000), which also needs function `funct_i` = 100000 (add) or 100010 (subtract); codes are ori 001101, lw 100011, sw 101011, beq 000100, jump 000010. At most one instruction matches.
- R2: add drives `rd_dest_o`=1, `rf_we_o`=1, `alu_op_o`=00 (add), and all other outputs 0.
- R3: subtract drives `rd_dest_o`=1, `rf_we_o`=1, `alu_op_o`=01 (subtract), and all other outputs 0.
- R4: ori drives `alu_b_imm_o`=1, `rf_we_o`=1, `imm_sext_o`=0 (zero extension), `alu_op_o`=10 (OR), and all other outputs 0.
- R5: lw drives `alu_b_imm_o`=1, `wb_mem_o`=1, `rf_we_o`=1, `imm_sext_o`=1, `alu_op_o`=00, and all other outputs 0.
- R6: sw drives `alu_b_imm_o`=1, `mem_we_o`=1, `imm_sext_o`=1, `alu_op_o`=00, with `rf_we_o`=0 and all other outputs 0.
- R7: beq drives `br_eq_o`=1, `alu_op_o`=01, with both write enables 0 and all other outputs 0.
- R8: jump drives `jump_o`=1 with both write enables 0, `alu_op_o`=00 and all other outputs 0.
- R9: An unlisted opcode, or opcode 000000 with a function other than 100000 or 100010, drives every output to 0.
- R10: For any opcode other than 000000, the value of `funct_i` has no effect on any output.
- R11: Outputs depend only on the present `opcode_i` and `funct_i` and follow a change of them within the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Instruction bits 31..26 |
| funct_i | input | 6 | Instruction bits 5..0 |
| rd_dest_o | output | 1 | Write-back register taken from the rd field |
| alu_b_imm_o | output | 1 | Second ALU operand is the extended immediate |
| wb_mem_o | output | 1 | Register write data comes from data memory |
| rf_we_o | output | 1 | Register file write enable |
| mem_we_o | output | 1 | Data memory write enable |
| br_eq_o | output | 1 | Next PC uses the equal-branch target |
| jump_o | output | 1 | Next PC uses the jump target |
| imm_sext_o | output | 1 | Immediate is sign extended (0: zero extended) |
| alu_op_o | output | 2 | ALU operation: 00 add, 01 subtract, 10 OR |

## Verification
The field widths are package constants that the instruction format fixes, so the bench builds the decoder in its only configuration. With 12 input bits, that lets the bench sweep every one of the 4096 opcode and function pairs against a behavioural reference. The sweep reaches every illegal register-format function, every unlisted opcode and every function value under each non-register opcode. Each vector is applied just after a rising edge and compared before the next one, which shows that the outputs settle without any clocked stage.

// File: rtl/scd_pkg.sv
package scd_pkg;

    localparam int OP_W   = 6;
    localparam int FN_W   = 6;
    localparam int ALU_W  = 2;
    localparam int N_KIND = 7;

    // Instruction slots in the match vector
    localparam int K_ADD = 0;
    localparam int K_SUB = 1;
    localparam int K_ORI = 2;
    localparam int K_LW  = 3;
    localparam int K_SW  = 4;
    localparam int K_BEQ = 5;
    localparam int K_JMP = 6;

    typedef enum logic [ALU_W-1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_OR  = 2'b10
    } alu_e;

    typedef struct packed {
        logic rd_dest;
        logic b_imm;
        logic wb_mem;
        logic rf_we;
        logic mem_we;
        logic br_eq;
        logic jmp;
        logic sext;
        alu_e alu;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    localparam logic [OP_W-1:0] OPC_REG = 6'b000000;
    localparam logic [OP_W-1:0] OPC_ORI = 6'b001101;
    localparam logic [OP_W-1:0] OPC_LW  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_SW  = 6'b101011;
    localparam logic [OP_W-1:0] OPC_BEQ = 6'b000100;
    localparam logic [OP_W-1:0] OPC_JMP = 6'b000010;
    localparam logic [FN_W-1:0] FN_ADD  = 6'b100000;
    localparam logic [FN_W-1:0] FN_SUB  = 6'b100010;

    function automatic logic [OP_W-1:0] kind_opcode(input int k);
        case (k)
            K_ORI:   return OPC_ORI;
            K_LW:    return OPC_LW;
            K_SW:    return OPC_SW;
            K_BEQ:   return OPC_BEQ;
            K_JMP:   return OPC_JMP;
            default: return OPC_REG;
        endcase
    endfunction

    function automatic logic kind_uses_funct(input int k);
        return (k == K_ADD) || (k == K_SUB);
    endfunction

    function automatic logic [FN_W-1:0] kind_funct(input int k);
        return (k == K_SUB) ? FN_SUB : FN_ADD;
    endfunction

    // Contribution of one instruction to the OR plane
    function automatic ctl_t kind_ctl(input int k);
        ctl_t c;
        c = '0;
        case (k)
            K_ADD: begin c.rd_dest = 1'b1; c.rf_we = 1'b1; c.alu = ALU_ADD; end
            K_SUB: begin c.rd_dest = 1'b1; c.rf_we = 1'b1; c.alu = ALU_SUB; end
            K_ORI: begin c.b_imm = 1'b1; c.rf_we = 1'b1; c.alu = ALU_OR; end
            K_LW:  begin c.b_imm = 1'b1; c.wb_mem = 1'b1; c.rf_we = 1'b1; c.sext = 1'b1; end
            K_SW:  begin c.b_imm = 1'b1; c.mem_we = 1'b1; c.sext = 1'b1; end
            K_BEQ: begin c.br_eq = 1'b1; c.alu = ALU_SUB; end
            K_JMP: begin c.jmp = 1'b1; end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/scd_match.sv
module scd_match
    import scd_pkg::*;
(
    input  logic [OP_W-1:0]   opcode,
    input  logic [FN_W-1:0]   funct,
    output logic [N_KIND-1:0] hit
);

    // AND plane: one term per instruction
    for (genvar g = 0; g < N_KIND; g++) begin : g_term
        localparam logic [OP_W-1:0] OPC = kind_opcode(g);
        localparam logic [FN_W-1:0] FNC = kind_funct(g);
        if (kind_uses_funct(g)) begin : g_reg
            assign hit[g] = (opcode == OPC) && (funct == FNC);
        end else begin : g_op
            assign hit[g] = (opcode == OPC);
        end
    end

endmodule

// File: rtl/scd_or_plane.sv
module scd_or_plane
    import scd_pkg::*;
(
    input  logic [N_KIND-1:0] hit,
    output ctl_t              ctl
);

    always_comb begin
        logic [CTL_W-1:0] acc;
        acc = '0;
        for (int k = 0; k < N_KIND; k++) begin
            if (hit[k]) acc = acc | kind_ctl(k);
        end
        ctl = ctl_t'(acc);
    end

    // Guards on the match vector arriving from the AND plane
    always_comb begin
        assert_onehot_hit_R1: assert ($onehot0(hit))
            else $error("more than one instruction matched");
        assert_nomatch_zero_R9: assert ((hit != '0) || (ctl == '0))
            else $error("control active with no match");
    end

endmodule

// File: rtl/sc_ctrl_decode.sv
module sc_ctrl_decode
    import scd_pkg::*;
(
    input  logic [OP_W-1:0]  opcode_i,
    input  logic [FN_W-1:0]  funct_i,
    output logic             rd_dest_o,
    output logic             alu_b_imm_o,
    output logic             wb_mem_o,
    output logic             rf_we_o,
    output logic             mem_we_o,
    output logic             br_eq_o,
    output logic             jump_o,
    output logic             imm_sext_o,
    output logic [ALU_W-1:0] alu_op_o
);

    logic [N_KIND-1:0] hit;
    ctl_t              ctl;

    scd_match u_match (
        .opcode (opcode_i),
        .funct  (funct_i),
        .hit    (hit)
    );

    scd_or_plane u_or (
        .hit (hit),
        .ctl (ctl)
    );

    assign rd_dest_o   = ctl.rd_dest;
    assign alu_b_imm_o = ctl.b_imm;
    assign wb_mem_o    = ctl.wb_mem;
    assign rf_we_o     = ctl.rf_we;
    assign mem_we_o    = ctl.mem_we;
    assign br_eq_o     = ctl.br_eq;
    assign jump_o      = ctl.jmp;
    assign imm_sext_o  = ctl.sext;
    assign alu_op_o    = ctl.alu;

    // Cross-checks between outputs of the OR plane and the raw opcode
    always_comb begin
        assert_load_writes_R5: assert (!wb_mem_o || rf_we_o)
            else $error("memory result selected without register write");
        assert_store_no_rf_R6: assert (!(mem_we_o && rf_we_o))
            else $error("store and register write together");
        assert_flow_no_write_R7: assert (!(br_eq_o || jump_o) || !(rf_we_o || mem_we_o))
            else $error("branch or jump writes state");
        assert_flow_excl_R8: assert (!(br_eq_o && jump_o))
            else $error("branch and jump together");
        assert_sext_imm_R4: assert (!imm_sext_o || alu_b_imm_o)
            else $error("sign extension without immediate operand");
        assert_reg_dest_R10: assert (!rd_dest_o || (opcode_i == OPC_REG))
            else $error("rd destination outside register format");
        assert_alu_code_R1: assert (alu_op_o != 2'b11)
            else $error("reserved ALU code");
    end

endmodule

// File: tb/sc_ctrl_decode_test.sv
module sc_ctrl_decode_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode;
    logic [5:0] funct;
    logic       rd_dest, b_imm, wb_mem, rf_we, mem_we, br_eq, jmp, sext;
    logic [1:0] alu_op;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sc_ctrl_decode uut (
        .opcode_i    (opcode),
        .funct_i     (funct),
        .rd_dest_o   (rd_dest),
        .alu_b_imm_o (b_imm),
        .wb_mem_o    (wb_mem),
        .rf_we_o     (rf_we),
        .mem_we_o    (mem_we),
        .br_eq_o     (br_eq),
        .jump_o      (jmp),
        .imm_sext_o  (sext),
        .alu_op_o    (alu_op)
    );

    // Reference: {rd_dest, b_imm, wb_mem, rf_we, mem_we, br_eq, jmp, sext, alu[1:0]}
    function automatic logic [9:0] model(input logic [5:0] op, input logic [5:0] fn);
        if (op == 6'd0 && fn == 6'd32) return 10'b1001_0000_00;
        if (op == 6'd0 && fn == 6'd34) return 10'b1001_0000_01;
        case (op)
            6'd13:   return 10'b0101_0000_10;
            6'd35:   return 10'b0111_0001_00;
            6'd43:   return 10'b0100_1001_00;
            6'd4:    return 10'b0000_0100_01;
            6'd2:    return 10'b0000_0010_00;
            default: return 10'b0;
        endcase
    endfunction

    function automatic string req_of(input logic [5:0] op, input logic [5:0] fn);
        if (op == 6'd0) begin
            if (fn == 6'd32) return "R2";
            if (fn == 6'd34) return "R3";
            return "R9";
        end
        if (fn != 6'd0 && (op == 6'd13 || op == 6'd35 || op == 6'd43 || op == 6'd4 || op == 6'd2))
            return "R10";
        case (op)
            6'd13:   return "R4";
            6'd35:   return "R5";
            6'd43:   return "R6";
            6'd4:    return "R7";
            6'd2:    return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic apply_check(input logic [5:0] op, input logic [5:0] fn);
        logic [9:0] act;
        logic [9:0] exp;
        @(posedge clk);
        #1;
        opcode = op;
        funct  = fn;
        @(negedge clk);
        act = {rd_dest, b_imm, wb_mem, rf_we, mem_we, br_eq, jmp, sext, alu_op};
        exp = model(op, fn);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R1 R11 %s op=%b fn=%b actual=%b expected=%b",
                     req_of(op, fn), op, fn, act, exp);
        end
    endtask

    initial begin
        opcode = 6'd0;
        funct  = 6'd0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset state: register format with an unused function gives all zeros (R9)
        apply_check(6'd0, 6'd0);
        // Directed cases, one per instruction (R2..R8)
        apply_check(6'd0,  6'd32);
        apply_check(6'd0,  6'd34);
        apply_check(6'd13, 6'd0);
        apply_check(6'd35, 6'd0);
        apply_check(6'd43, 6'd0);
        apply_check(6'd4,  6'd0);
        apply_check(6'd2,  6'd0);
        // Boundary: near-miss functions and opcodes (R9), function under ori (R10)
        apply_check(6'd0,  6'd33);
        apply_check(6'd0,  6'd2);
        apply_check(6'd12, 6'd0);
        apply_check(6'd13, 6'd34);
        apply_check(6'd63, 6'd63);
        // Back-to-back changes each cycle (R11)
        apply_check(6'd43, 6'd32);
        apply_check(6'd35, 6'd32);
        // Exhaustive sweep of all opcode/function pairs (R1, R9, R10)
        for (int i = 0; i < 4096; i++) begin
            apply_check(6'(i >> 6), 6'(i));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule